// File: doc/BRIEF.md
# 2D Rectangle Fill and Vertical Scroll Engine

This block is a small drawing engine for a framebuffer with 32-bit pixels and a line pitch of 2048 words. A host programs it through a plain register write bus. The host sets an opcode, a raster operation, a foreground colour, a source corner, a destination corner, a height and a width. Writing the width starts the job. The engine then walks the rectangle over a single-port memory interface and holds a busy flag until it has written the last pixel.

The engine runs two jobs. The first is a solid rectangle fill, which can overwrite pixels with the colour or XOR the colour into them. The second is a vertical scroll copy between two rectangles that share the same X position. The copy picks its row order so that overlapping source and destination areas are copied correctly. Each pixel needs one memory cycle when it is only written, and two cycles (read, then write) when the old value is needed. The memory returns read data in the cycle after a read request.

Top module: `blit_engine`

## Requirements
- R1: After reset, busy_o and mem_req_o are low, and the registers hold opcode 0x00, raster op 0x83, and zero for colour, corners and height.
- R2: Register select codes on reg_addr_i: 0 opcode (bits 7:0), 1 raster op (bits 7:0), 2 colour (32 bits), 3 source Y, 4 source X, 5 destination Y, 6 destination X, 7 height, 8 width (bits 11:0). A write to code 8 while idle starts a job. The height and width are 12-bit values and the coordinates are 11-bit values.
- R3: Opcode 0x08 with raster op 0x83 writes the colour to every pixel of the rectangle. The corner is (source Y, source X) and the order is row-major from the top-left. The engine writes one pixel per cycle at word address y*2048+x.
- R4: A fill with raster op 0x86 reads each pixel, then writes colour XOR the returned data in the next cycle, so it takes two cycles per pixel.
- R5: A fill with raster op 0x85 makes no memory access and busy_o stays low. Any raster op code other than 0x85 and 0x86 acts as 0x83.
- R6: Opcode 0x0b copies each source pixel at (source Y + r, source X + c) to (destination Y + r, destination X + c). For each pixel it issues a read, then a write of the returned data in the next cycle.
- R7: In a scroll, rows go top to bottom when the destination Y is smaller than the source Y, and bottom to top otherwise. Within a row, columns always go left to right.
- R8: A scroll whose source X differs from its destination X, or whose source Y equals its destination Y, does nothing. Any opcode other than 0x08 and 0x0b also does nothing.
- R9: A zero width or zero height ends the job at once: busy_o never rises and no memory access is made.
- R10: While busy_o is high, every register write is ignored, including the colour and the width.
- R11: busy_o rises in the cycle after the width write and falls in the cycle after the final pixel write. mem_req_o is high in every busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| busy_o | output | 1 | Job in progress |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 22 | Pixel word address |
| mem_wdata_o | output | 32 | Pixel write data |
| mem_rdata_i | input | 32 | Read data, one cycle after the read |

## Verification
The hardest case to reach from the ports is an overlapping scroll in which the wrong row order would silently read rows that have already been overwritten. To reach it, the stimulus preloads memory with address-dependent values and then scrolls a rectangle up and down by fewer rows than its height. Because the reference model replays the writes in its own order, a wrong direction shows up as a data mismatch on the write bus. A second hard case is a register write landing mid-job. The bench issues colour and width writes while a long fill is running, then restarts without rewriting the colour, so that a write that was not ignored becomes visible in the later pixels.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam logic [7:0] OP_FILL    = 8'h08;
  localparam logic [7:0] OP_VSCROLL = 8'h0b;
  localparam logic [7:0] ROP_NEW    = 8'h83;
  localparam logic [7:0] ROP_OLD    = 8'h85;
  localparam logic [7:0] ROP_XOR    = 8'h86;

  typedef enum logic [3:0] {
    SEL_OPCODE = 4'd0,
    SEL_ROP    = 4'd1,
    SEL_COLOR  = 4'd2,
    SEL_SRC_Y  = 4'd3,
    SEL_SRC_X  = 4'd4,
    SEL_DST_Y  = 4'd5,
    SEL_DST_X  = 4'd6,
    SEL_HEIGHT = 4'd7,
    SEL_WIDTH  = 4'd8
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUT,
    ST_GET,
    ST_MIX
  } blit_st_e;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 11,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  output logic [7:0]    op_o,
  output logic [7:0]    rop_o,
  output logic [DW-1:0] fg_o,
  output logic [YW-1:0] sy_o,
  output logic [XW-1:0] sx_o,
  output logic [YW-1:0] dy_o,
  output logic [XW-1:0] dx_o,
  output logic [YW:0]   h_o,
  output logic          start_o
);
  logic acc;
  assign acc     = we_i && !busy_i;
  assign start_o = acc && (addr_i == SEL_WIDTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o  <= '0;
      rop_o <= ROP_NEW;
      fg_o  <= '0;
      sy_o  <= '0;
      sx_o  <= '0;
      dy_o  <= '0;
      dx_o  <= '0;
      h_o   <= '0;
    end else if (acc) begin
      case (addr_i)
        SEL_OPCODE: op_o  <= wdata_i[7:0];
        SEL_ROP:    rop_o <= wdata_i[7:0];
        SEL_COLOR:  fg_o  <= wdata_i;
        SEL_SRC_Y:  sy_o  <= wdata_i[YW-1:0];
        SEL_SRC_X:  sx_o  <= wdata_i[XW-1:0];
        SEL_DST_Y:  dy_o  <= wdata_i[YW-1:0];
        SEL_DST_X:  dx_o  <= wdata_i[XW-1:0];
        SEL_HEIGHT: h_o   <= wdata_i[YW:0];
        default: ;
      endcase
    end
  end

  // R10: host writes during a job leave the programmed state untouched
  assert_busy_write_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && busy_i) |=> ($stable(fg_o) && $stable(op_o) && $stable(h_o) && $stable(sy_o)));
endmodule

// File: rtl/blit_walk.sv
module blit_walk #(
  parameter int XW = 11,
  parameter int YW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [XW-1:0] cmax_i,
  input  logic [YW-1:0] rmax_i,
  input  logic          step_i,
  output logic [XW-1:0] col_o,
  output logic [YW-1:0] row_o,
  output logic          last_o
);
  logic [XW-1:0] cmax_q;
  logic [YW-1:0] rmax_q;
  logic          row_end;

  assign row_end = (col_o == cmax_q);
  assign last_o  = row_end && (row_o == rmax_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmax_q <= '0;
      rmax_q <= '0;
      col_o  <= '0;
      row_o  <= '0;
    end else if (load_i) begin
      cmax_q <= cmax_i;
      rmax_q <= rmax_i;
      col_o  <= '0;
      row_o  <= '0;
    end else if (step_i) begin
      if (row_end) begin
        col_o <= '0;
        row_o <= row_o + YW'(1);
      end else begin
        col_o <= col_o + XW'(1);
      end
    end
  end

  // R3: every job starts at the first column of the first row
  assert_walk_origin_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (col_o == '0 && row_o == '0));
  // R3: row-major wrap at the end of a row
  assert_walk_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && row_end && !last_o) |=> (col_o == '0));
endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 11,
  parameter int DW = 32,
  localparam int AW = XW + YW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  logic [7:0]    op, rop;
  logic [DW-1:0] fg;
  logic [YW-1:0] sy, dy;
  logic [XW-1:0] sx, dx;
  logic [YW:0]   h;
  logic          start;

  blit_regs #(.XW(XW), .YW(YW), .DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy_o),
    .op_o(op), .rop_o(rop), .fg_o(fg),
    .sy_o(sy), .sx_o(sx), .dy_o(dy), .dx_o(dx), .h_o(h),
    .start_o(start)
  );

  blit_st_e      st_q;
  logic          scroll_q, xor_q, rev_q;
  logic [XW:0]   new_w;
  logic          size_zero, is_fill, is_scroll, go, step, last;
  logic [XW-1:0] col;
  logic [YW-1:0] row, hm1, row_eff, src_y, dst_y;
  logic [XW-1:0] pix_x;

  assign new_w     = reg_wdata_i[XW:0];
  assign size_zero = (new_w == '0) || (h == '0);
  assign is_fill   = (op == OP_FILL);
  assign is_scroll = (op == OP_VSCROLL) && (sx == dx) && (sy != dy);
  assign go        = start && !size_zero && ((is_fill && rop != ROP_OLD) || is_scroll);
  assign hm1       = h[YW-1:0] - YW'(1);
  assign step      = (st_q == ST_PUT) || (st_q == ST_MIX);

  blit_walk #(.XW(XW), .YW(YW)) u_walk (
    .clk_i, .rst_ni,
    .load_i(go),
    .cmax_i(new_w[XW-1:0] - XW'(1)),
    .rmax_i(hm1),
    .step_i(step),
    .col_o(col), .row_o(row), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      scroll_q <= 1'b0;
      xor_q    <= 1'b0;
      rev_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (go) begin
          scroll_q <= is_scroll;
          xor_q    <= is_fill && (rop == ROP_XOR);
          rev_q    <= is_scroll && (dy > sy);  // destination below: walk rows upward
          st_q     <= (is_scroll || rop == ROP_XOR) ? ST_GET : ST_PUT;
        end
        ST_PUT:  if (last) st_q <= ST_IDLE;
        ST_GET:  st_q <= ST_MIX;
        ST_MIX:  st_q <= last ? ST_IDLE : ST_GET;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign row_eff = rev_q ? (hm1 - row) : row;
  assign src_y   = sy + row_eff;
  assign dst_y   = scroll_q ? (dy + row_eff) : src_y;
  assign pix_x   = sx + col;

  assign busy_o      = (st_q != ST_IDLE);
  assign mem_req_o   = busy_o;
  assign mem_we_o    = step;
  assign mem_addr_o  = (st_q == ST_GET) ? {src_y, pix_x} : {dst_y, pix_x};
  assign mem_wdata_o = scroll_q ? mem_rdata_i : (xor_q ? (fg ^ mem_rdata_i) : fg);

  // R4/R6: a read is always followed by its write in the next cycle
  assert_read_then_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> (mem_req_o && mem_we_o));
  // R11: busy drops only right after a pixel write
  assert_busy_ends_on_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mem_req_o && mem_we_o));
  // R9: empty rectangle never raises busy
  assert_zero_size_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && size_zero) |=> !busy_o);
  // R8: scroll with mismatched X is dropped
  assert_scroll_x_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && op == OP_VSCROLL && sx != dx) |=> !busy_o);
endmodule

// File: tb/blit_engine_tb.sv
module blit_engine_tb;
  localparam int XW = 11;
  localparam int YW = 11;
  localparam int AW = XW + YW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        busy, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  blit_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  typedef struct {
    bit          we;
    int          addr;
    logic [31:0] data;
  } txn_t;

  txn_t        exp_q[$];
  logic [31:0] mem [int];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          exp_busy = 1'b0;
  string       cur_req = "R1";

  // bench shadow of programmed registers
  int          m_op = 0, m_rop = 'h83, m_sy = 0, m_sx = 0, m_dy = 0, m_dx = 0, m_h = 0;
  logic [31:0] m_fg = '0;

  function automatic logic [31:0] seed_val(int a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A_1234;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory: one-cycle read latency
  always @(posedge clk) begin
    if (rst_n && mem_req) begin
      if (mem_we) mem[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : seed_val(int'(mem_addr));
    end
  end

  // cycle-by-cycle comparison against the expected transaction stream
  always @(negedge clk) begin
    if (rst_n) begin
      exp_busy = (exp_q.size() != 0);
      chk(busy === exp_busy, cur_req, "busy", 64'(busy), 64'(exp_busy));
      if (mem_req === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_req, "unexpected access addr", 64'(mem_addr), 64'd0);
        end else begin
          txn_t t;
          t = exp_q.pop_front();
          chk(mem_we === t.we, cur_req, "we", 64'(mem_we), 64'(t.we));
          chk(int'(mem_addr) == t.addr, cur_req, "addr", 64'(mem_addr), 64'(t.addr));
          if (t.we) chk(mem_wdata === t.data, cur_req, "wdata", 64'(mem_wdata), 64'(t.data));
        end
      end
    end
  end

  function automatic int pa(int y, int x);
    return y * 2048 + x;
  endfunction

  task automatic build(int w);
    logic [31:0] sh [int];
    bit fill_ok, scr_ok;
    sh = mem;
    fill_ok = (m_op == 'h08) && (m_rop != 'h85);
    scr_ok  = (m_op == 'h0b) && (m_sx == m_dx) && (m_sy != m_dy);
    if (w == 0 || m_h == 0 || !(fill_ok || scr_ok)) return;
    for (int i = 0; i < m_h; i++) begin
      int r;
      r = (scr_ok && m_dy > m_sy) ? (m_h - 1 - i) : i;
      for (int c = 0; c < w; c++) begin
        int sa, da;
        logic [31:0] old;
        sa = pa(m_sy + r, m_sx + c);
        da = scr_ok ? pa(m_dy + r, m_dx + c) : sa;
        old = sh.exists(sa) ? sh[sa] : seed_val(sa);
        if (scr_ok) begin
          exp_q.push_back('{1'b0, sa, 32'h0});
          exp_q.push_back('{1'b1, da, old});
          sh[da] = old;
        end else if (m_rop == 'h86) begin
          exp_q.push_back('{1'b0, sa, 32'h0});
          exp_q.push_back('{1'b1, da, m_fg ^ old});
          sh[da] = m_fg ^ old;
        end else begin
          exp_q.push_back('{1'b1, da, m_fg});
          sh[da] = m_fg;
        end
      end
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(posedge clk); #6;
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    if (!exp_busy) begin
      case (a)
        0: m_op = int'(d[7:0]);
        1: m_rop = int'(d[7:0]);
        2: m_fg = d;
        3: m_sy = int'(d[10:0]);
        4: m_sx = int'(d[10:0]);
        5: m_dy = int'(d[10:0]);
        6: m_dx = int'(d[10:0]);
        7: m_h = int'(d[11:0]);
        8: build(int'(d[11:0]));
        default: ;
      endcase
    end
    @(posedge clk); #6;
    reg_we = 1'b0;
  endtask

  task automatic settle();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic setup(int op, int rop, logic [31:0] fg, int sy, int sx, int dy, int dx, int h);
    wr(0, op); wr(1, rop); wr(2, fg);
    wr(3, sy); wr(4, sx); wr(5, dy); wr(6, dx); wr(7, h);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(posedge clk);
      cnt++;
      if (cnt > 100000) begin
        chk(1'b0, "watchdog", "timeout", 64'(cnt), 64'd100000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs during and after reset
    chk(busy === 1'b0, "R1", "busy in reset", 64'(busy), 64'd0);
    chk(mem_req === 1'b0, "R1", "req in reset", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk); #2;
    chk(busy === 1'b0 && mem_req === 1'b0, "R1", "idle after reset", 64'({busy, mem_req}), 64'd0);

    // R1/R2: reset raster op 0x83 acts as overwrite
    cur_req = "R2";
    wr(0, 'h08); wr(2, 32'h1111_2222); wr(3, 1); wr(4, 1); wr(7, 1); wr(8, 2);
    settle();

    // R3: overwrite fill, one pixel per cycle, row-major
    cur_req = "R3";
    setup('h08, 'h83, 32'hA5A5_0001, 2, 5, 0, 0, 3);
    wr(8, 4);
    settle();
    chk(mem[pa(4, 8)] === 32'hA5A5_0001, "R3", "last pixel", 64'(mem[pa(4, 8)]), 64'hA5A5_0001);

    // R4: XOR fill, read then write
    cur_req = "R4";
    setup('h08, 'h86, 32'hF0F0_0F0F, 2, 4, 0, 0, 2);
    wr(8, 3);
    settle();
    chk(mem[pa(3, 6)] === (32'hF0F0_0F0F ^ 32'hA5A5_0001), "R4", "xor pixel",
        64'(mem[pa(3, 6)]), 64'(32'hF0F0_0F0F ^ 32'hA5A5_0001));

    // R5: keep-old raster op, and unknown raster op acting as overwrite
    cur_req = "R5";
    setup('h08, 'h85, 32'hDEAD_BEEF, 20, 20, 0, 0, 2);
    wr(8, 2);
    settle();
    chk(!mem.exists(pa(20, 20)), "R5", "keep-old untouched", 64'(mem.exists(pa(20, 20))), 64'd0);
    setup('h08, 'h11, 32'h0BAD_CAFE, 21, 30, 0, 0, 1);
    wr(8, 3);
    settle();

    // R6/R7: scroll up, overlapping, top to bottom
    cur_req = "R7";
    setup('h0b, 'h85, 32'h0, 40, 3, 38, 3, 4);
    wr(8, 3);
    settle();
    chk(mem[pa(38, 3)] === seed_val(pa(40, 3)), "R6", "scroll up pixel",
        64'(mem[pa(38, 3)]), 64'(seed_val(pa(40, 3))));
    // scroll down, overlapping, bottom to top
    setup('h0b, 'h85, 32'h0, 60, 7, 62, 7, 4);
    wr(8, 2);
    settle();
    chk(mem[pa(65, 8)] === seed_val(pa(63, 8)), "R7", "scroll down pixel",
        64'(mem[pa(65, 8)]), 64'(seed_val(pa(63, 8))));

    // R8: rejected scrolls and unsupported opcode
    cur_req = "R8";
    setup('h0b, 'h85, 32'h0, 80, 3, 82, 4, 2);
    wr(8, 2);
    settle();
    setup('h0b, 'h85, 32'h0, 80, 3, 80, 3, 2);
    wr(8, 2);
    settle();
    setup('h0a, 'h83, 32'h1234_5678, 80, 3, 82, 3, 2);
    wr(8, 2);
    settle();
    chk(!mem.exists(pa(82, 3)), "R8", "no write on reject", 64'(mem.exists(pa(82, 3))), 64'd0);

    // R9: zero width and zero height
    cur_req = "R9";
    setup('h08, 'h83, 32'h7777_7777, 90, 0, 0, 0, 3);
    wr(8, 0);
    settle();
    wr(7, 0);
    wr(8, 5);
    settle();
    chk(!mem.exists(pa(90, 0)), "R9", "zero size untouched", 64'(mem.exists(pa(90, 0))), 64'd0);

    // R10/R11: writes during busy ignored; restart uses old colour
    cur_req = "R10";
    setup('h08, 'h83, 32'h5555_AAAA, 100, 0, 0, 0, 2);
    wr(8, 12);
    wr(2, 32'h9999_9999);
    wr(8, 1);
    wr(7, 7);
    settle();
    cur_req = "R11";
    wr(3, 101);
    wr(8, 2);
    settle();
    chk(mem[pa(101, 1)] === 32'h5555_AAAA, "R10", "colour kept", 64'(mem[pa(101, 1)]), 64'h5555_AAAA);
    chk(exp_q.size() == 0, "R11", "all transactions seen", 64'(exp_q.size()), 64'd0);

    finish_run();
  end
endmodule